// File: doc/BRIEF.md
# Masked Breakpoint Comparator Group

This block is one slice of a debug breakpoint unit. It keeps four 32-bit point registers and a small control word. Two comparators, called comparator A (hit bit 0) and comparator B (hit bit 1), inspect a stream of address or data values. Depending on the control word, each comparator does an exact match, a masked match or an inclusive range check. The point registers are shared: control bits decide which register acts as a bound and which acts as a mask. A paired mode moves comparator A onto the upper pair of points.

Point registers are written through a flat register index that covers every group of the larger unit. The group answers only to the four indices whose upper bits equal its `GROUP_IDX` parameter. The control word has its own write strobe. Hit flags are registered and appear one clock after a valid input value.

Top module: `bp_group`

## Requirements
- R1: A point write (`pt_we`=1) lands in point `pt_addr[1:0]` only when `pt_addr[ADDR_W-1:2]` equals `GROUP_IDX`, so the flat index is group*4+point. Writes to any other group's indices leave all four points unchanged.
- R2: A point or control write takes effect at the clock edge that ends its cycle. A compare presented in the same cycle as a write uses the old contents.
- R3: `ctl_wdata` bit layout: bit0 range A, bit1 range B, bit2 mask-enable A, bit3 mask-enable B, bit4 point-enable A, bit5 unit enable, bit6 pair select. Synchronous reset clears the control word, all points and both hit flags, so range detection is off after reset.
- R4: With range A on and outside paired mode, comparator A hits when point0 <= value <= point1, with both bounds inclusive.
- R5: With range B on, comparator B hits when point2 <= value <= point3, with both bounds inclusive.
- R6: A mask bit of 1 removes that bit position from a comparison. In range mode with masking enabled, the mask clears the same bits of both bounds and of the value before the ordered compare. Comparator B's mask is always point0.
- R7: Outside paired mode, comparator A's mask is point2 if point-enable A or range A is set. Otherwise its mask is point0.
- R8: Paired mode is unit enable AND pair select. In paired mode comparator A uses point2 as its lower bound or match target, point3 as its upper bound and point0 as its mask. Point-enable A and range A then have no effect on mask choice.
- R9: With range off, comparator A does an equality match against point0 (point2 in paired mode) and comparator B against point2. Each match is masked when its mask enable is set.
- R10: `hit` is registered one cycle after `in_valid`. A cycle with `in_valid`=0 gives `hit`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_we | input | 1 | Point register write strobe |
| pt_addr | input | ADDR_W | Flat point index (group*4+point) |
| pt_wdata | input | DATA_W | Point write data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word write data |
| in_valid | input | 1 | Compare value is valid |
| in_value | input | DATA_W | Address or data value to compare |
| hit | output | 2 | Registered hit flags, bit0 comparator A, bit1 comparator B |

## Verification
The bench hits both range bounds exactly and one step outside each. A design with an off-by-one or strict compare would drop a hit at point0/point3 or raise one at a neighbour. It chooses values whose outcome differs depending on which register is the mask: point0 versus point2 for comparator A, with and without paired mode. A wrong mask route then flips the hit. It also issues writes aimed at a neighbouring group's indices, and a write in the same cycle as a compare. Address decoding that ignores the group bits would corrupt point0, and a bypassed write path would show the new value one cycle early.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int NPT   = 4;
  localparam int SEL_W = 2;
  localparam int CTL_W = 7;

  // bit0 is range_a, bit6 is pair_sel
  typedef struct packed {
    logic pair_sel;
    logic unit_en;
    logic pt_en_a;
    logic mask_en_b;
    logic mask_en_a;
    logic range_b;
    logic range_a;
  } bp_ctl_t;
endpackage

// File: rtl/bp_point_regs.sv
module bp_point_regs
  import bp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int GROUP_IDX = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        pt_we,
  input  logic [ADDR_W-1:0]           pt_addr,
  input  logic [DATA_W-1:0]           pt_wdata,
  input  logic                        ctl_we,
  input  logic [CTL_W-1:0]            ctl_wdata,
  output logic [NPT-1:0][DATA_W-1:0]  pts,
  output bp_ctl_t                     ctl
);
  localparam int GRP_W = ADDR_W - SEL_W;
  localparam logic [GRP_W-1:0] GRP_ID = GRP_W'(GROUP_IDX);

  logic grp_hit;
  assign grp_hit = pt_we && (pt_addr[ADDR_W-1:SEL_W] == GRP_ID);

  for (genvar gi = 0; gi < NPT; gi++) begin : g_pt
    always_ff @(posedge clk) begin
      if (rst) begin
        pts[gi] <= '0;
      end else if (grp_hit && (pt_addr[SEL_W-1:0] == SEL_W'(gi))) begin
        pts[gi] <= pt_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (ctl_we) begin
      ctl <= bp_ctl_t'(ctl_wdata);
    end
  end
endmodule

// File: rtl/bp_route.sv
module bp_route
  import bp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NPT-1:0][DATA_W-1:0] pts,
  input  bp_ctl_t                    ctl,
  output logic [1:0][DATA_W-1:0]     lo,
  output logic [1:0][DATA_W-1:0]     hi,
  output logic [1:0][DATA_W-1:0]     msk,
  output logic [1:0]                 rng,
  output logic [1:0]                 men
);
  logic paired;
  assign paired = ctl.unit_en & ctl.pair_sel;

  always_comb begin
    // comparator A
    if (paired) begin
      lo[0]  = pts[2];
      hi[0]  = pts[3];
      msk[0] = pts[0];
    end else begin
      lo[0]  = pts[0];
      hi[0]  = pts[1];
      msk[0] = (ctl.pt_en_a | ctl.range_a) ? pts[2] : pts[0];
    end
    // comparator B
    lo[1]  = pts[2];
    hi[1]  = pts[3];
    msk[1] = pts[0];
    rng    = {ctl.range_b, ctl.range_a};
    men    = {ctl.mask_en_b, ctl.mask_en_a};
  end
endmodule

// File: rtl/bp_cmp.sv
module bp_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] msk,
  input  logic              rng,
  input  logic              men,
  output logic              match
);
  logic [DATA_W-1:0] keep, v_k, lo_k, hi_k;

  always_comb begin
    keep  = men ? ~msk : '1;
    v_k   = value & keep;
    lo_k  = lo & keep;
    hi_k  = hi & keep;
    match = rng ? ((v_k >= lo_k) && (v_k <= hi_k)) : (v_k == lo_k);
  end
endmodule

// File: rtl/bp_group.sv
module bp_group
  import bp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NGROUPS   = 8,
  parameter int GROUP_IDX = 0,
  parameter int ADDR_W    = $clog2(NGROUPS * NPT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pt_we,
  input  logic [ADDR_W-1:0] pt_addr,
  input  logic [DATA_W-1:0] pt_wdata,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_value,
  output logic [1:0]        hit
);
  logic [NPT-1:0][DATA_W-1:0] pt_q;
  bp_ctl_t                    ctl_q;
  logic [1:0][DATA_W-1:0]     bnd_lo, bnd_hi, bnd_msk;
  logic [1:0]                 cmp_rng, cmp_men, cmp_match;

  bp_point_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GROUP_IDX(GROUP_IDX)
  ) u_regs (
    .clk(clk), .rst(rst),
    .pt_we(pt_we), .pt_addr(pt_addr), .pt_wdata(pt_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .pts(pt_q), .ctl(ctl_q)
  );

  bp_route #(.DATA_W(DATA_W)) u_route (
    .pts(pt_q), .ctl(ctl_q),
    .lo(bnd_lo), .hi(bnd_hi), .msk(bnd_msk),
    .rng(cmp_rng), .men(cmp_men)
  );

  for (genvar ci = 0; ci < 2; ci++) begin : g_cmp
    bp_cmp #(.DATA_W(DATA_W)) u_cmp (
      .value(in_value), .lo(bnd_lo[ci]), .hi(bnd_hi[ci]), .msk(bnd_msk[ci]),
      .rng(cmp_rng[ci]), .men(cmp_men[ci]), .match(cmp_match[ci])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= '0;
    else     hit <= in_valid ? cmp_match : 2'b00;
  end
endmodule

// File: rtl/bp_group_chk.sv
module bp_group_chk
  import bp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [DATA_W-1:0]          in_value,
  input logic [1:0]                 hit,
  input logic [NPT-1:0][DATA_W-1:0] pts,
  input bp_ctl_t                    ctl,
  input logic [1:0][DATA_W-1:0]     lo,
  input logic [1:0][DATA_W-1:0]     hi,
  input logic [1:0][DATA_W-1:0]     msk
);
  a_r3_reset_clear: assert property (@(posedge clk)
    rst |=> hit == 2'b00);

  a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> hit == 2'b00);

  a_r4_range_a_inside: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctl.range_a && !ctl.mask_en_a && !(ctl.unit_en && ctl.pair_sel)
     && in_value >= pts[0] && in_value <= pts[1]) |=> hit[0]);

  a_r5_range_b_outside: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctl.range_b && !ctl.mask_en_b
     && (in_value < pts[2] || in_value > pts[3])) |=> !hit[1]);

  a_r8_paired_route: assert property (@(posedge clk) disable iff (rst)
    (ctl.unit_en && ctl.pair_sel) |-> (lo[0] == pts[2] && hi[0] == pts[3] && msk[0] == pts[0]));

  a_r7_mask_a_pick: assert property (@(posedge clk) disable iff (rst)
    (!(ctl.unit_en && ctl.pair_sel) && (ctl.pt_en_a || ctl.range_a)) |-> msk[0] == pts[2]);

  a_r6_mask_b_src: assert property (@(posedge clk) disable iff (rst)
    msk[1] == pts[0]);
endmodule

bind bp_group bp_group_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value), .hit(hit),
  .pts(pt_q), .ctl(ctl_q), .lo(bnd_lo), .hi(bnd_hi), .msk(bnd_msk)
);

// File: tb/test_bp_group.sv
`timescale 1ns/1ps
module test_bp_group;
  localparam int GRP = 2;
  localparam logic [6:0] RNG_A = 7'h01, RNG_B = 7'h02, MSK_A = 7'h04, MSK_B = 7'h08,
                         PTEN_A = 7'h10, UNIT = 7'h20, PAIR = 7'h40;

  logic        clk = 0, rst = 1;
  logic        pt_we = 0, ctl_we = 0, in_valid = 0;
  logic [4:0]  pt_addr = '0;
  logic [31:0] pt_wdata = '0, in_value = '0;
  logic [6:0]  ctl_wdata = '0;
  logic [1:0]  hit;

  bp_group #(.DATA_W(32), .NGROUPS(8), .GROUP_IDX(GRP)) i_bp_group (
    .clk(clk), .rst(rst), .pt_we(pt_we), .pt_addr(pt_addr), .pt_wdata(pt_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .in_valid(in_valid), .in_value(in_value),
    .hit(hit)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  logic [31:0] m_pt [4] = '{default: 32'h0};
  logic [6:0]  m_ctl = '0;
  int          q_stamp[$];
  logic [1:0]  q_exp[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] model(input logic [31:0] v);
    logic pr;
    logic [31:0] lo_a, hi_a, mk_a, mk_b;
    logic [1:0] r;
    pr   = m_ctl[5] & m_ctl[6];
    lo_a = pr ? m_pt[2] : m_pt[0];
    hi_a = pr ? m_pt[3] : m_pt[1];
    mk_a = pr ? m_pt[0] : ((m_ctl[4] | m_ctl[0]) ? m_pt[2] : m_pt[0]);
    if (!m_ctl[2]) mk_a = '0;
    mk_b = m_ctl[3] ? m_pt[0] : '0;
    r[0] = m_ctl[0] ? (((v & ~mk_a) >= (lo_a & ~mk_a)) && ((v & ~mk_a) <= (hi_a & ~mk_a)))
                    : ((v & ~mk_a) == (lo_a & ~mk_a));
    r[1] = m_ctl[1] ? (((v & ~mk_b) >= (m_pt[2] & ~mk_b)) && ((v & ~mk_b) <= (m_pt[3] & ~mk_b)))
                    : ((v & ~mk_b) == (m_pt[2] & ~mk_b));
    return r;
  endfunction

  // monitor: compares results one clock after their driving cycle
  always @(negedge clk) begin
    while (q_stamp.size() > 0 && q_stamp[0] < cyc) begin
      checks++;
      if (hit !== q_exp[0]) begin
        errors++;
        $display("FAIL %s: hit=%b expected=%b", q_tag[0], hit, q_exp[0]);
      end
      void'(q_stamp.pop_front());
      void'(q_exp.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic push_exp(input logic v, input logic [31:0] val, input string tag);
    q_stamp.push_back(cyc);
    q_exp.push_back(v ? model(val) : 2'b00);
    q_tag.push_back(tag);
  endtask

  task automatic step(input logic v, input logic [31:0] val, input string tag);
    @(negedge clk);
    push_exp(v, val, tag);
    in_valid = v; in_value = val; pt_we = 0; ctl_we = 0;
  endtask

  task automatic wr_pt(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 0; ctl_we = 0; pt_we = 1; pt_addr = a; pt_wdata = d;
    if (a[4:2] == 3'(GRP)) m_pt[a[1:0]] = d;
  endtask

  task automatic wr_ctl(input logic [6:0] c);
    @(negedge clk);
    in_valid = 0; pt_we = 0; ctl_we = 1; ctl_wdata = c;
    m_ctl = c;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (hit !== 2'b00) begin
      errors++; $display("FAIL R3 reset: hit=%b expected=00", hit);
    end
    rst = 0;

    // R1: load this group's points at flat indices 8..11
    wr_pt(5'd8,  32'h100);
    wr_pt(5'd9,  32'h1FF);
    wr_pt(5'd10, 32'h300);
    wr_pt(5'd11, 32'h3FF);
    // R1: neighbouring groups' indices must be ignored
    wr_pt(5'd4,  32'h555);
    wr_pt(5'd14, 32'h777);
    step(1, 32'h100, "R1 foreign write ignored, point0 kept");
    step(1, 32'h555, "R1 foreign data absent");
    step(1, 32'h300, "R9 B equality vs point2");
    // R3: range off after reset: inside-window value must not hit
    step(1, 32'h150, "R3 range disabled after reset");

    // R4 range A inclusive bounds
    wr_ctl(RNG_A);
    step(1, 32'h100, "R4 lower bound");
    step(1, 32'h1FF, "R4 upper bound");
    step(1, 32'h0FF, "R4 below lower");
    step(1, 32'h200, "R4 above upper");

    // R5 range B inclusive bounds
    wr_ctl(RNG_B);
    step(1, 32'h300, "R5 lower bound");
    step(1, 32'h3FF, "R5 upper bound");
    step(1, 32'h400, "R5 above upper");
    step(1, 32'h2FF, "R5 below lower");

    // R7 mask choice for comparator A outside paired mode
    wr_ctl(MSK_A);
    step(1, 32'h200, "R7 mask from point0");
    wr_ctl(MSK_A | PTEN_A);
    step(1, 32'h200, "R7 mask from point2 via point-enable");

    // R6 masked range on B, mask = point0 (0x100)
    wr_ctl(RNG_B | MSK_B);
    step(1, 32'h250, "R6 masked range inside");
    step(1, 32'h3FF, "R6 masked upper bound");
    step(1, 32'h150, "R6 masked below");

    // R8 paired mode
    wr_ctl(UNIT | PAIR | RNG_A);
    step(1, 32'h350, "R8 paired range inside");
    step(1, 32'h150, "R8 paired old window");
    wr_ctl(UNIT | PAIR | MSK_A | PTEN_A);
    step(1, 32'h000, "R8 paired mask from point0");
    step(1, 32'h200, "R8 paired masked target point2");
    wr_ctl(UNIT | RNG_A);
    step(1, 32'h350, "R8 unit only is not paired");

    // R10 no hit without valid
    wr_ctl(7'h00);
    step(0, 32'h100, "R10 idle no hit");
    step(1, 32'h100, "R10 valid hit");

    // R2 write and compare in the same cycle
    @(negedge clk);
    push_exp(1, 32'h100, "R2 compare sees old point0");
    in_valid = 1; in_value = 32'h100; ctl_we = 0;
    pt_we = 1; pt_addr = 5'd8; pt_wdata = 32'h700;
    m_pt[0] = 32'h700;
    step(1, 32'h700, "R2 new point0 visible");
    step(1, 32'h100, "R2 old point0 gone");
    step(0, 32'h0, "R10 tail idle");

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule